// File: doc/BRIEF.md
# Staged Pipeline Control Generator

This block turns the instruction word in the decode stage of a five-stage processor pipeline into the control lines that the later stages need. A combinational decoder reads the 6-bit opcode and builds three control groups: an execute group, a memory group and a write-back group. Three stage registers then carry the groups forward, one stage per clock. Each stage drops the group it has used, so the bundle gets smaller as it moves down the pipe.

No state machine sequences these lines. Each line reaches its stage because of the fixed delay of the stage registers. The register numbers rt and rd also go into the first stage register. The execute stage picks one of them as the destination, and that destination then travels with the memory and write-back controls. This way a register write acts on the register named by its own instruction. The stage registers load every cycle. A reset empties them, and an unrecognised opcode gives an all-zero bundle, so in both cases the stage behaves as a bubble.

Top module: `pipe_ctl_gen`

## Requirements
- R1: Instruction fields are taken from fixed bit positions: opcode [31:26], rt [20:16] and rd [15:11]. Bits [25:21] and [10:0] have no effect on any output.
- R2: Opcode 0 (register-register format) gives dst_sel=1, imm_sel=0, alu_mode=2'b10, memory group all 0, reg_we=1 and load_sel=0.
- R3: Opcode 35 (load) gives dst_sel=0, imm_sel=1, alu_mode=2'b00, mem_rd=1, branch=0, mem_wr=0, reg_we=1 and load_sel=1.
- R4: Opcode 43 (store) gives imm_sel=1, alu_mode=2'b00, mem_wr=1, branch=0, mem_rd=0 and reg_we=0. Its don't-care lines dst_sel and load_sel are driven 0.
- R5: Opcode 4 (branch-if-equal) gives imm_sel=0, alu_mode=2'b01, branch=1, mem_rd=0, mem_wr=0 and reg_we=0. Its don't-care lines dst_sel and load_sel are driven 0.
- R6: Any other opcode gives all-zero control in every group, so the slot acts as a bubble.
- R7: An instruction presented before clock edge k shows its execute group after edge k, its memory group after edge k+1 and its write-back group after edge k+2.
- R8: The destination is rd when dst_sel=1 and rt otherwise. It is shown with the execute group and travels unchanged to the memory and write-back outputs.
- R9: An asynchronous active-low reset clears every output to 0 at once. Release is taken on a clock edge.
- R10: A new instruction is accepted every cycle with no stall. Back-to-back instructions never mix in any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word in the decode stage |
| ex_dst_sel_o | output | 1 | Execute: destination is rd (1) or rt (0) |
| ex_imm_sel_o | output | 1 | Execute: second ALU operand is the immediate |
| ex_alu_mode_o | output | 2 | Execute: ALU operation class |
| ex_dest_o | output | 5 | Execute: selected destination register |
| mem_branch_o | output | 1 | Memory: branch decision enable |
| mem_rd_o | output | 1 | Memory: data read |
| mem_wr_o | output | 1 | Memory: data write |
| mem_dest_o | output | 5 | Memory: carried destination register |
| wb_reg_we_o | output | 1 | Write-back: register file write enable |
| wb_load_sel_o | output | 1 | Write-back: write data comes from memory (1) or ALU (0) |
| wb_dest_o | output | 5 | Write-back: register to write |

## Verification
A wrong bit in any stage register shows up at that stage's outputs in the very next cycle. A bad decode or a bad stage register also gives a control value that belongs to a different opcode class than the one entered. A destination that is selected wrongly, or that slips by a cycle, shows up at the write-back output two cycles after the execute output: the register number there no longer matches the instruction whose write enable is raised. The sweep runs every opcode value, with changing rt and rd values, through the pipe back to back. It checks all three stages every cycle, so a shift or a swap between neighbouring slots cannot go unseen.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  typedef struct packed {
    logic       dst_sel;
    logic       imm_sel;
    logic [1:0] alu_mode;
  } ex_ctl_t;

  typedef struct packed {
    logic branch;
    logic mem_rd;
    logic mem_wr;
  } mem_ctl_t;

  typedef struct packed {
    logic reg_we;
    logic load_sel;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ctl_t;

  localparam int EX_W  = $bits(ex_ctl_t);
  localparam int MEM_W = $bits(mem_ctl_t);
  localparam int WB_W  = $bits(wb_ctl_t);
  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int OPW       = 6,
  parameter int OP_RTYPE  = 0,
  parameter int OP_LOAD   = 35,
  parameter int OP_STORE  = 43,
  parameter int OP_BRANCH = 4
) (
  input  logic [OPW-1:0] op_i,
  output ctl_t           ctl_o
);

  localparam logic [OPW-1:0] C_RTYPE  = OPW'(OP_RTYPE);
  localparam logic [OPW-1:0] C_LOAD   = OPW'(OP_LOAD);
  localparam logic [OPW-1:0] C_STORE  = OPW'(OP_STORE);
  localparam logic [OPW-1:0] C_BRANCH = OPW'(OP_BRANCH);

  // Pure translation, no state; unknown opcodes fall to an all-zero bubble.
  always_comb begin
    ctl_o = '0;
    case (op_i)
      C_RTYPE: begin
        ctl_o.ex.dst_sel  = 1'b1;
        ctl_o.ex.alu_mode = 2'b10;
        ctl_o.wb.reg_we   = 1'b1;
      end
      C_LOAD: begin
        ctl_o.ex.imm_sel  = 1'b1;
        ctl_o.ex.alu_mode = 2'b00;
        ctl_o.mem.mem_rd  = 1'b1;
        ctl_o.wb.reg_we   = 1'b1;
        ctl_o.wb.load_sel = 1'b1;
      end
      C_STORE: begin
        ctl_o.ex.imm_sel  = 1'b1;
        ctl_o.ex.alu_mode = 2'b00;
        ctl_o.mem.mem_wr  = 1'b1;
      end
      C_BRANCH: begin
        ctl_o.ex.alu_mode = 2'b01;
        ctl_o.mem.branch  = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/pcg_stage_reg.sv
module pcg_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end

endmodule

// File: rtl/pipe_ctl_gen.sv
module pipe_ctl_gen
  import pcg_pkg::*;
#(
  parameter int IW        = 32,
  parameter int OPW       = 6,
  parameter int REGW      = 5,
  parameter int OP_RTYPE  = 0,
  parameter int OP_LOAD   = 35,
  parameter int OP_STORE  = 43,
  parameter int OP_BRANCH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   instr_i,
  output logic            ex_dst_sel_o,
  output logic            ex_imm_sel_o,
  output logic [1:0]      ex_alu_mode_o,
  output logic [REGW-1:0] ex_dest_o,
  output logic            mem_branch_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [REGW-1:0] mem_dest_o,
  output logic            wb_reg_we_o,
  output logic            wb_load_sel_o,
  output logic [REGW-1:0] wb_dest_o
);

  // Field layout derived from the word width, opcode at the top.
  localparam int OP_LSB = IW - OPW;
  localparam int RS_LSB = OP_LSB - REGW;
  localparam int RT_LSB = RS_LSB - REGW;
  localparam int RD_LSB = RT_LSB - REGW;

  localparam int IDEX_W  = CTL_W + 2 * REGW;
  localparam int EXMEM_W = MEM_W + WB_W + REGW;
  localparam int MEMWB_W = WB_W + REGW;

  // Stage registers load on every cycle.
  localparam logic STAGE_EN = 1'b1;

  logic [OPW-1:0]  id_op;
  logic [REGW-1:0] id_rt;
  logic [REGW-1:0] id_rd;
  ctl_t            id_ctl;
  logic            unused_fields;

  assign id_op = instr_i[IW-1:OP_LSB];
  assign id_rt = instr_i[RT_LSB +: REGW];
  assign id_rd = instr_i[RD_LSB +: REGW];
  assign unused_fields = ^{instr_i[RS_LSB +: REGW], instr_i[RD_LSB-1:0]};

  pcg_decode #(
    .OPW      (OPW),
    .OP_RTYPE (OP_RTYPE),
    .OP_LOAD  (OP_LOAD),
    .OP_STORE (OP_STORE),
    .OP_BRANCH(OP_BRANCH)
  ) u_dec (
    .op_i (id_op),
    .ctl_o(id_ctl)
  );

  // Decode -> execute: full bundle plus both candidate destinations.
  logic [IDEX_W-1:0] idex_d, idex_q;
  ctl_t              ex_ctl;
  logic [REGW-1:0]   ex_rt, ex_rd, ex_dest;

  assign idex_d = {id_ctl, id_rt, id_rd};

  pcg_stage_reg #(.W(IDEX_W)) u_idex (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (STAGE_EN),
    .d_i  (idex_d),
    .q_o  (idex_q)
  );

  assign {ex_ctl, ex_rt, ex_rd} = idex_q;
  assign ex_dest = ex_ctl.ex.dst_sel ? ex_rd : ex_rt;

  // Execute -> memory: execute group is consumed and dropped.
  logic [EXMEM_W-1:0] exmem_d, exmem_q;
  mem_ctl_t           mem_ctl;
  wb_ctl_t            mem_wb;
  logic [REGW-1:0]    mem_dest;

  assign exmem_d = {ex_ctl.mem, ex_ctl.wb, ex_dest};

  pcg_stage_reg #(.W(EXMEM_W)) u_exmem (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (STAGE_EN),
    .d_i  (exmem_d),
    .q_o  (exmem_q)
  );

  assign {mem_ctl, mem_wb, mem_dest} = exmem_q;

  // Memory -> write-back: only the write-back group and destination remain.
  logic [MEMWB_W-1:0] memwb_d, memwb_q;
  wb_ctl_t            wb_ctl;
  logic [REGW-1:0]    wb_dest;

  assign memwb_d = {mem_wb, mem_dest};

  pcg_stage_reg #(.W(MEMWB_W)) u_memwb (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (STAGE_EN),
    .d_i  (memwb_d),
    .q_o  (memwb_q)
  );

  assign {wb_ctl, wb_dest} = memwb_q;

  assign ex_dst_sel_o  = ex_ctl.ex.dst_sel;
  assign ex_imm_sel_o  = ex_ctl.ex.imm_sel;
  assign ex_alu_mode_o = ex_ctl.ex.alu_mode;
  assign ex_dest_o     = ex_dest;
  assign mem_branch_o  = mem_ctl.branch;
  assign mem_rd_o      = mem_ctl.mem_rd;
  assign mem_wr_o      = mem_ctl.mem_wr;
  assign mem_dest_o    = mem_dest;
  assign wb_reg_we_o   = wb_ctl.reg_we;
  assign wb_load_sel_o = wb_ctl.load_sel;
  assign wb_dest_o     = wb_dest;

endmodule

// File: rtl/pcg_chk.sv
module pcg_chk #(
  parameter int IW        = 32,
  parameter int OPW       = 6,
  parameter int REGW      = 5,
  parameter int OP_LOAD   = 35,
  parameter int OP_STORE  = 43
) (
  input logic            clk,
  input logic            rst_n,
  input logic [IW-1:0]   instr_i,
  input logic            ex_dst_sel_o,
  input logic            ex_imm_sel_o,
  input logic [1:0]      ex_alu_mode_o,
  input logic [REGW-1:0] ex_dest_o,
  input logic            mem_branch_o,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic [REGW-1:0] mem_dest_o,
  input logic            wb_reg_we_o,
  input logic            wb_load_sel_o,
  input logic [REGW-1:0] wb_dest_o
);

  logic id_mem_op;
  assign id_mem_op = (instr_i[IW-1:IW-OPW] == OPW'(OP_LOAD)) ||
                     (instr_i[IW-1:IW-OPW] == OPW'(OP_STORE));

  AST_RTYPE_EX_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    ex_dst_sel_o |-> (ex_alu_mode_o == 2'b10 && !ex_imm_sel_o)); // R2

  AST_LOAD_REACHES_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (wb_reg_we_o && wb_load_sel_o)); // R3

  AST_STORE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> !wb_reg_we_o); // R4

  AST_MEM_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_branch_o, mem_rd_o, mem_wr_o})); // R5

  AST_EX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ex_imm_sel_o == $past(id_mem_op))); // R7

  AST_DEST_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mem_dest_o == $past(ex_dest_o))); // R8

  AST_DEST_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (wb_dest_o == $past(mem_dest_o))); // R8

endmodule

bind pipe_ctl_gen pcg_chk u_chk (.*);

// File: tb/tb_pipe_ctl_gen.sv
module tb_pipe_ctl_gen;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr_i;
  logic        ex_dst_sel_o, ex_imm_sel_o;
  logic [1:0]  ex_alu_mode_o;
  logic [4:0]  ex_dest_o, mem_dest_o, wb_dest_o;
  logic        mem_branch_o, mem_rd_o, mem_wr_o;
  logic        wb_reg_we_o, wb_load_sel_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam logic [31:0] BUBBLE = 32'hFC00_0000; // opcode 63, rt=rd=0

  pipe_ctl_gen dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  typedef struct packed {
    logic [3:0] ex;   // dst_sel, imm_sel, alu_mode
    logic [2:0] mem;  // branch, rd, wr
    logic [1:0] wb;   // reg_we, load_sel
    logic [4:0] dest;
  } exp_t;

  // R1: opcode [31:26], rt [20:16], rd [15:11]
  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic [5:0] op = w[31:26];
    e = '0;
    case (op)
      6'd0:  begin e.ex = 4'b1010; e.wb = 2'b10; end
      6'd35: begin e.ex = 4'b0100; e.mem = 3'b010; e.wb = 2'b11; end
      6'd43: begin e.ex = 4'b0100; e.mem = 3'b001; end
      6'd4:  begin e.ex = 4'b0001; e.mem = 3'b100; end
      default: ;
    endcase
    e.dest = e.ex[3] ? w[15:11] : w[20:16];
    return e;
  endfunction

  function automatic string req_of(input logic [31:0] w);
    case (w[31:26])
      6'd0:  return "R2";
      6'd35: return "R3";
      6'd43: return "R4";
      6'd4:  return "R5";
      default: return "R6";
    endcase
  endfunction

  // Sweep: all 64 opcodes first, then a dense mix of the four classes; noise in ignored fields (R1).
  function automatic logic [31:0] gen(input int i, input int salt);
    logic [5:0] op;
    logic [4:0] rt, rd, rs;
    logic [10:0] lo;
    int k = i + salt;
    if (i < 64) op = 6'(i);
    else case (k % 5)
      0: op = 6'd0; 1: op = 6'd35; 2: op = 6'd43; 3: op = 6'd4; default: op = 6'(k * 13);
    endcase
    rt = 5'(k * 3 + 1);
    rd = 5'(k * 7 + 5);
    rs = 5'(k * 11);
    lo = 11'(k * 97);
    return {op, rs, rt, rd, lo};
  endfunction

  task automatic check(input string req, input string what, input logic [13:0] act, input logic [13:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all_zero(input string req);
    check(req, "reset ex", {8'd0, ex_dst_sel_o, ex_imm_sel_o, ex_alu_mode_o, 2'd0}, 14'd0);
    check(req, "reset dest", {ex_dest_o, mem_dest_o, wb_dest_o[3:0]}, 14'd0);
    check(req, "reset mem/wb", {7'd0, mem_branch_o, mem_rd_o, mem_wr_o, wb_reg_we_o, wb_load_sel_o, 1'b0, wb_dest_o[4]}, 14'd0);
  endtask

  // R7, R10: back-to-back stream; stage k shows the instruction from k cycles back.
  task automatic run_seq(input int n, input int salt);
    logic [31:0] h1, h2, h3;
    exp_t e;
    h1 = BUBBLE; h2 = BUBBLE; h3 = BUBBLE;
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk);
      e = model(h1);
      check({req_of(h1), "/R7"}, "execute group",
            {10'd0, ex_dst_sel_o, ex_imm_sel_o, ex_alu_mode_o}, {10'd0, e.ex});
      check("R8", "execute dest", {9'd0, ex_dest_o}, {9'd0, e.dest});
      e = model(h2);
      check({req_of(h2), "/R7"}, "memory group",
            {6'd0, mem_branch_o, mem_rd_o, mem_wr_o, mem_dest_o}, {6'd0, e.mem, e.dest});
      e = model(h3);
      check({req_of(h3), "/R10"}, "write-back group",
            {7'd0, wb_reg_we_o, wb_load_sel_o, wb_dest_o}, {7'd0, e.wb, e.dest});
      h3 = h2; h2 = h1;
      h1 = (i < n) ? gen(i, salt) : BUBBLE;
      instr_i = h1;
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    instr_i = BUBBLE;
    repeat (3) @(negedge clk);
    check_all_zero("R9");
    rst_n = 1'b1;

    run_seq(200, 0);

    // R9: asynchronous clear in the middle of a loaded pipe
    @(negedge clk); instr_i = {6'd35, 5'd1, 5'd9, 5'd3, 11'd0};
    @(negedge clk); instr_i = {6'd0, 5'd2, 5'd4, 5'd17, 11'd0};
    @(negedge clk); instr_i = BUBBLE;
    #3 rst_n = 1'b0;
    #1 check_all_zero("R9");
    @(negedge clk); rst_n = 1'b1;

    run_seq(120, 3);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule